// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. A tester drives a test clock, a mode-select line and a serial data input. The block walks the standard sixteen-state test controller and shifts a four-bit instruction. It then shifts data through whichever data register that instruction selects, and returns serial data on an enabled output.

Inside the block are the instruction register, a one-bit bypass stage, a fixed 32-bit identification word and an 8-bit clock-divider register. The divider register's value goes to the core. The boundary cell chain is outside the block. The block drives that chain with capture, shift and update strobes and a select flag, and takes the chain's serial return on one input.

The block decodes four mode flags for the core: external test, clamp, output float and lockout recovery. Two configuration inputs gate the whole port. When they are not in the compliant setting, the controller is held in reset.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: The controller follows the standard sixteen-state graph on rising TCK edges under TMS. Five consecutive rising edges with TMS high reach Test-Logic-Reset from any state.
- R2: The controller is forced asynchronously into Test-Logic-Reset, with tdo_oe and every strobe low, while any of these holds: trst_n is low, cfg_test is 1, or cfg_en is 0.
- R3: The instruction register is 4 bits wide and its LSB is shifted out first. Capture-IR loads 0001. A shifted instruction takes effect in Update-IR. Test-Logic-Reset selects IDCODE (0001).
- R4: IDCODE (0001) selects a 32-bit identification register. It reloads 0x05C1E01D in Capture-DR and shifts out LSB first.
- R5: A 1-bit register that captures 0 sits between tdi and tdo for these opcodes: 0011, 0100, 0101, 1001, 1100 and 1111, and every opcode without another assignment (0110, 0111, 1000, 1010, 1101, 1110).
- R6: EXTEST (0000) and SAMPLE (0010) raise bnd_sel and route bnd_so to tdo during Shift-DR.
- R7: mode_extest is high for 0000, mode_clamp for 1100, mode_highz for 1001 and mode_unlock for 1011. At most one of them is high at a time.
- R8: Opcode 1011 selects an 8-bit divider register that captures the current clkdiv value. clkdiv takes the shifted value in Update-DR, and only under opcode 1011. Its reset value is 0.
- R9: tdo and tdo_oe change on falling TCK edges. tdo_oe is high only while the state is Shift-DR or Shift-IR.
- R10: capture_dr, shift_dr and update_dr are each high exactly while the controller is in Capture-DR, Shift-DR or Update-DR respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in |
| trst_n | input | 1 | Asynchronous test reset, active low |
| cfg_test | input | 1 | Compliance input, must be 0 for operation |
| cfg_en | input | 1 | Compliance input, must be 1 for operation |
| bnd_so | input | 1 | Serial return from external boundary chain |
| tdo | output | 1 | Serial data out, falling-edge timed |
| tdo_oe | output | 1 | Output enable for tdo |
| bnd_sel | output | 1 | Boundary chain is the active data register |
| mode_extest | output | 1 | Boundary cells drive the pins |
| mode_clamp | output | 1 | Boundary drive held, values untouched |
| mode_highz | output | 1 | Core must float every output driver |
| mode_unlock | output | 1 | Lockout recovery instruction active |
| clkdiv | output | DIV_W | Divider value delivered to the core |
| capture_dr | output | 1 | Capture strobe for data registers |
| shift_dr | output | 1 | Shift strobe for data registers |
| update_dr | output | 1 | Update strobe for data registers |

## Verification
Two events can land on the same TCK edge. The edge that leaves Update-DR commits the divider. The same edge belongs to a scan whose shifted-out bits are the old divider value captured in that scan. The sweep over all sixteen opcodes provokes this: each divider scan writes a new pattern and must read back the one written before it. A second collision is a reset request that arrives asynchronously in the middle of Shift-DR. The bench judges it without a clock edge by checking that the strobes and the output enable fall at once.

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl #(
  parameter logic [31:0] ID_VALUE = 32'h05C1E01D,
  parameter int          DIV_W    = 8
) (
  input  logic             tck,
  input  logic             tms,
  input  logic             tdi,
  input  logic             trst_n,
  input  logic             cfg_test,
  input  logic             cfg_en,
  input  logic             bnd_so,
  output logic             tdo,
  output logic             tdo_oe,
  output logic             bnd_sel,
  output logic             mode_extest,
  output logic             mode_clamp,
  output logic             mode_highz,
  output logic             mode_unlock,
  output logic [DIV_W-1:0] clkdiv,
  output logic             capture_dr,
  output logic             shift_dr,
  output logic             update_dr
);

  localparam int IR_W = 4;
  localparam int ID_W = 32;
  localparam logic [IR_W-1:0] OP_EXTEST = 4'b0000;
  localparam logic [IR_W-1:0] OP_IDCODE = 4'b0001;
  localparam logic [IR_W-1:0] OP_SAMPLE = 4'b0010;
  localparam logic [IR_W-1:0] OP_FLOAT  = 4'b1001;
  localparam logic [IR_W-1:0] OP_UNLOCK = 4'b1011;
  localparam logic [IR_W-1:0] OP_CLAMP  = 4'b1100;
  localparam logic [IR_W-1:0] IR_CAPT   = 4'b0001;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PA_DR, EX2_DR, UP_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PA_IR, EX2_IR, UP_IR
  } tap_st_t;

  tap_st_t st, st_nx;
  logic [IR_W-1:0]  ir, ir_sr;
  logic [ID_W-1:0]  id_sr;
  logic [DIV_W-1:0] div_sr;
  logic             byp;
  logic             dr_bit;
  logic             rst_n;
  logic             sel_id, sel_div;

  assign rst_n = trst_n & ~cfg_test & cfg_en;

  always_comb begin
    case (st)
      TLR:     st_nx = tms ? TLR    : RTI;
      RTI:     st_nx = tms ? SEL_DR : RTI;
      SEL_DR:  st_nx = tms ? SEL_IR : CAP_DR;
      CAP_DR:  st_nx = tms ? EX1_DR : SH_DR;
      SH_DR:   st_nx = tms ? EX1_DR : SH_DR;
      EX1_DR:  st_nx = tms ? UP_DR  : PA_DR;
      PA_DR:   st_nx = tms ? EX2_DR : PA_DR;
      EX2_DR:  st_nx = tms ? UP_DR  : SH_DR;
      UP_DR:   st_nx = tms ? SEL_DR : RTI;
      SEL_IR:  st_nx = tms ? TLR    : CAP_IR;
      CAP_IR:  st_nx = tms ? EX1_IR : SH_IR;
      SH_IR:   st_nx = tms ? EX1_IR : SH_IR;
      EX1_IR:  st_nx = tms ? UP_IR  : PA_IR;
      PA_IR:   st_nx = tms ? EX2_IR : PA_IR;
      EX2_IR:  st_nx = tms ? UP_IR  : SH_IR;
      UP_IR:   st_nx = tms ? SEL_DR : RTI;
      default: st_nx = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n) st <= TLR;
    else        st <= st_nx;

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n) begin
      ir    <= OP_IDCODE;
      ir_sr <= '0;
    end else begin
      case (st)
        CAP_IR:  ir_sr <= IR_CAPT;
        SH_IR:   ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        UP_IR:   ir    <= ir_sr;
        TLR:     ir    <= OP_IDCODE;
        default: ;
      endcase
    end

  assign sel_id      = (ir == OP_IDCODE);
  assign sel_div     = (ir == OP_UNLOCK);
  assign bnd_sel     = (ir == OP_EXTEST) || (ir == OP_SAMPLE);
  assign mode_extest = (ir == OP_EXTEST);
  assign mode_clamp  = (ir == OP_CLAMP);
  assign mode_highz  = (ir == OP_FLOAT);
  assign mode_unlock = sel_div;

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n) begin
      byp    <= 1'b0;
      id_sr  <= '0;
      div_sr <= '0;
      clkdiv <= '0;
    end else begin
      case (st)
        CAP_DR: begin
          byp <= 1'b0;
          if (sel_id)  id_sr  <= ID_VALUE;
          if (sel_div) div_sr <= clkdiv;
        end
        SH_DR: begin
          byp <= tdi;
          if (sel_id)  id_sr  <= {tdi, id_sr[ID_W-1:1]};
          if (sel_div) div_sr <= {tdi, div_sr[DIV_W-1:1]};
        end
        UP_DR: if (sel_div) clkdiv <= div_sr;
        default: ;
      endcase
    end

  assign dr_bit = sel_id  ? id_sr[0]  :
                  sel_div ? div_sr[0] :
                  bnd_sel ? bnd_so    : byp;

  always_ff @(negedge tck or negedge rst_n)
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= (st == SH_IR) ? ir_sr[0] : (st == SH_DR) ? dr_bit : 1'b0;
      tdo_oe <= (st == SH_IR) || (st == SH_DR);
    end

  assign capture_dr = (st == CAP_DR);
  assign shift_dr   = (st == SH_DR);
  assign update_dr  = (st == UP_DR);

  // R9
  oe_shift_chk: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe == (st == SH_DR || st == SH_IR));

  // R7
  flags_excl_chk: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot0({mode_extest, mode_clamp, mode_highz, mode_unlock}));

  // R8
  div_write_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !$stable(clkdiv) |-> $past(st == UP_DR && sel_div));

  // R3
  ir_write_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !$stable(ir) |-> $past(st == UP_IR || st == TLR));

  // R10
  cap_to_shift_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (capture_dr && !tms) |=> shift_dr);

endmodule

// File: tb/jtag_tap_ctrl_bench.sv
module jtag_tap_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;
  localparam logic [31:0] ID = 32'h05C1E01D;

  logic tck = 0, tms = 1, tdi = 0, trst_n = 0, cfg_test = 0, cfg_en = 1, bnd_so = 1;
  logic tdo, tdo_oe, bnd_sel, m_ext, m_clamp, m_hz, m_unl;
  logic [7:0] clkdiv;
  logic cap_dr, sh_dr, up_dr;
  logic smp, smp_oe;
  int checks = 0, fails = 0;
  logic [7:0] div_model = 8'h00;

  jtag_tap_ctrl u_jtag_tap_ctrl (
    .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n), .cfg_test(cfg_test),
    .cfg_en(cfg_en), .bnd_so(bnd_so), .tdo(tdo), .tdo_oe(tdo_oe),
    .bnd_sel(bnd_sel), .mode_extest(m_ext), .mode_clamp(m_clamp),
    .mode_highz(m_hz), .mode_unlock(m_unl), .clkdiv(clkdiv),
    .capture_dr(cap_dr), .shift_dr(sh_dr), .update_dr(up_dr));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    #(HALF - 1);
    smp = tdo; smp_oe = tdo_oe;
    #1 tck = 1;
    #HALF tck = 0;
  endtask

  task automatic to_idle();
    for (int i = 0; i < 5; i++) step(1, 0);
    step(0, 0);
  endtask

  task automatic scan_ir(input logic [3:0] op, output logic [3:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, op[i]);
      cap[i] = smp;
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din,
                         output logic [31:0] dout, output logic oe_ok);
    dout = '0; oe_ok = 1;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      dout[i] = smp;
      if (!smp_oe) oe_ok = 0;
    end
    step(1, 0); step(0, 0);
  endtask

  function automatic logic [7:0] exp_dr(input logic [3:0] op, input logic [7:0] d,
                                        input logic [7:0] dv);
    case (op)
      4'b0001: return ID[7:0];
      4'b1011: return dv;
      4'b0000, 4'b0010: return 8'hFF;
      default: return {d[6:0], 1'b0};
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0]  cap;
    logic [31:0] dout;
    logic        ok;
    #(CLK_PERIOD);
    chk("R2 oe in reset", {31'b0, tdo_oe}, 0);
    chk("R8 clkdiv reset", {24'b0, clkdiv}, 0);
    trst_n = 1;
    #2;
    to_idle();
    chk("R7 flags after reset", {28'b0, m_ext, m_clamp, m_hz, m_unl}, 0);
    chk("R9 oe idle", {31'b0, tdo_oe}, 0);

    scan_dr(32, 32'h0, dout, ok);
    chk("R4 id after reset", dout, ID);
    chk("R9 oe during shift", {31'b0, ok}, 1);

    // R10 strobes
    step(1, 0); step(0, 0);
    chk("R10 capture", {29'b0, cap_dr, sh_dr, up_dr}, 3'b100);
    step(0, 0);
    chk("R10 shift", {29'b0, cap_dr, sh_dr, up_dr}, 3'b010);
    step(1, 0); step(1, 0);
    chk("R10 update", {29'b0, cap_dr, sh_dr, up_dr}, 3'b001);
    step(0, 0);
    chk("R10 idle", {29'b0, cap_dr, sh_dr, up_dr}, 3'b000);

    // sweep all opcodes: R3 R5 R6 R7 R8
    for (int op = 0; op < 16; op++) begin
      logic [3:0] o;
      logic [7:0] d;
      o = op[3:0];
      d = 8'h5A ^ {o, o};
      scan_ir(o, cap);
      chk("R3 ir capture", {28'b0, cap}, 4'b0001);
      chk("R7 mode flags", {28'b0, m_ext, m_clamp, m_hz, m_unl},
          {28'b0, o == 4'b0000, o == 4'b1100, o == 4'b1001, o == 4'b1011});
      chk("R6 bnd_sel", {31'b0, bnd_sel}, {31'b0, (o == 4'b0000 || o == 4'b0010)});
      scan_dr(8, {24'b0, d}, dout, ok);
      chk("R5 dr path", dout, {24'b0, exp_dr(o, d, div_model)});
      if (o == 4'b1011) div_model = d;
      chk("R8 clkdiv", {24'b0, clkdiv}, {24'b0, div_model});
    end

    // R8 back-to-back divider writes read the previous value
    scan_ir(4'b1011, cap);
    scan_dr(8, 32'h3C, dout, ok);
    chk("R8 readback", dout, {24'b0, div_model});
    scan_dr(8, 32'hC3, dout, ok);
    chk("R8 readback2", dout, 32'h3C);
    chk("R8 commit", {24'b0, clkdiv}, 32'hC3);
    scan_ir(4'b1111, cap);
    scan_dr(8, 32'h11, dout, ok);
    chk("R8 no write under bypass", {24'b0, clkdiv}, 32'hC3);

    // R1 five TMS-high edges from Shift-DR
    step(1, 0); step(0, 0); step(0, 0);
    to_idle();
    scan_dr(32, 32'h0, dout, ok);
    chk("R1 tms reset to idcode", dout, ID);

    // R2 compliance hold
    scan_ir(4'b1111, cap);
    cfg_test = 1;
    step(1, 0); step(0, 0); step(0, 0);
    chk("R2 test hold", {30'b0, sh_dr, tdo_oe}, 0);
    cfg_test = 0; cfg_en = 0;
    step(0, 0);
    chk("R2 enable hold", {30'b0, sh_dr, cap_dr}, 0);
    cfg_en = 1;
    #2;
    step(0, 0);
    scan_dr(32, 32'h0, dout, ok);
    chk("R2 ir back to idcode", dout, ID);

    // R2 async trst in Shift-DR
    step(1, 0); step(0, 0); step(0, 0); step(0, 1);
    chk("R10 in shift", {31'b0, sh_dr}, 1);
    trst_n = 0;
    #1;
    chk("R2 async trst", {30'b0, sh_dr, tdo_oe}, 0);
    trst_n = 1;
    #1;
    step(0, 0);
    chk("R1 idle after trst", {29'b0, cap_dr, sh_dr, up_dr}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule